// File: doc/BRIEF.md
# Modulus Down-Counter With Reload

This block is a 16-bit down-counter driven through a prescaler that divides the clock by 1, 4, 8 or 16. It runs in one of two modes. In one-shot mode it counts down from a loaded value and then rests at zero. In modulus mode it refills itself from a load register each time it passes zero, so it acts as a periodic tick source.

When the count reaches zero, a sticky zero flag is raised. An interrupt line follows that flag when the interrupt enable bit is set. Software drives the block through three word-wide registers:

- a control word;
- a status word that holds the zero flag;
- a count/load word.

It starts a count with a self-clearing force-load command in the control word. While the counter is switched off, the count sits at 0xFFFF. This means no early zero flag can appear when counting starts. A newly chosen prescale rate waits for the next load before it takes effect.

Top module: `modulus_downcounter`

## Requirements
- R1: Control bits [1:0] choose the divide rate: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 16. After a load of value L at a clock edge, the count steps down once every D cycles, so it reaches zero L*D cycles after the load.
- R2: A write that changes control bits [1:0] leaves the rate in use unchanged. The new rate applies from the next load, which is a force-load, a count write in modulus mode, or a modulus refill.
- R3: While control bit 2 (run) is 0, the count reads 0xFFFF and the zero flag is never set.
- R4: When control bit 6 is 0 (one-shot), the counter stops at 0x0000 and stays there. In this mode a write to the count register (address 2) changes only the load register.
- R5: When control bit 6 is 1 (modulus), the count goes from 0x0000 to the load register value on the next prescaled step. In this mode a write to address 2 while running loads the count at once.
- R6: Writing control bit 3 as 1 while run is already 1 copies the load register into the count and restarts the prescaler. The same write while stopped does nothing, and bit 3 always reads back 0.
- R7: Control bit 5 selects what a read of address 2 returns: 0 returns the live count, 1 returns the load register.
- R8: The zero flag is status bit 7 at address 1. It is set when a prescaled step moves the count from 1 to 0. Writing 1 to it clears it and writing 0 does nothing. If a set and a clear fall in the same cycle, the set wins.
- R9: When control bit 8 is 1, any read strobe or write to address 2 clears the zero flag. When control bit 8 is 0, such accesses leave the flag alone.
- R10: `irq` is high exactly when the zero flag is set and control bit 7 is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| rd_en | input | 1 | Read strobe, used only for fast flag clearing |
| addr | input | 2 | Register select: 0 control, 1 status, 2 count/load |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data for `addr` |
| irq | output | 1 | Interrupt request |

## Verification
Two things can land in the same clock edge:

- the zero flag being set by the count reaching zero;
- software clearing that flag with a write-one to status bit 7.

The bench runs the counter in modulus mode with a short period, so zero is reached on a fixed, known cycle. It times a clear write so that it lands exactly on that edge. It then expects the flag to remain set. A second clear issued one cycle away from any zero crossing must drop the flag, which shows that the clear path itself works.

// File: rtl/mdc_pkg.sv
package mdc_pkg;
  localparam int ADDR_W = 2;

  localparam logic [1:0] ADR_CTRL  = 2'd0;
  localparam logic [1:0] ADR_STAT  = 2'd1;
  localparam logic [1:0] ADR_COUNT = 2'd2;

  // control word bit positions
  localparam int B_RUN   = 2;
  localparam int B_FORCE = 3;
  localparam int B_SHOW  = 5;
  localparam int B_MOD   = 6;
  localparam int B_IE    = 7;
  localparam int B_FAST  = 8;
  // status word bit position
  localparam int B_ZERO  = 7;

  // divide rate for a prescale select code: 1, then 4, 8, 16, ...
  function automatic int unsigned div_of(input int unsigned sel);
    return (sel == 0) ? 1 : (32'd1 << (sel + 1));
  endfunction
endpackage

// File: rtl/mdc_prescaler.sv
module mdc_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  import mdc_pkg::*;

  localparam int PRE_W = 2 ** SEL_W;

  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] limit;

  assign limit = PRE_W'(div_of(32'(sel)) - 32'd1);
  assign tick  = run && !restart && (pcnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       pcnt <= '0;
    else if (!run || restart || tick) pcnt <= '0;
    else                              pcnt <= pcnt + 1'b1;
  end

  AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= limit); // R1
endmodule

// File: rtl/mdc_counter.sv
module mdc_counter #(
  parameter int CNT_W = 16,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             modulus,
  input  logic             load_now,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic [SEL_W-1:0] sel_req,
  output logic [CNT_W-1:0] cnt_q,
  output logic             zero_hit
);
  logic [SEL_W-1:0] act_sel;
  logic             tick;
  logic             reload_evt;
  logic             step_evt;

  function automatic logic [CNT_W-1:0] down_step(input logic [CNT_W-1:0] v);
    return v - 1'b1;
  endfunction

  mdc_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (load_now),
    .sel     (act_sel),
    .tick    (tick)
  );

  // named internal events
  assign step_evt   = run && !load_now && tick && (cnt_q != '0);
  assign reload_evt = run && !load_now && tick && (cnt_q == '0) && modulus;
  assign zero_hit   = step_evt && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '1;
    else if (!run)       cnt_q <= '1;
    else if (load_now)   cnt_q <= load_val;
    else if (reload_evt) cnt_q <= reload_val;
    else if (step_evt)   cnt_q <= down_step(cnt_q);
  end

  // rate in use changes only when the count is (re)loaded
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             act_sel <= '0;
    else if ((run && load_now) || reload_evt) act_sel <= sel_req;
  end

  AST_PRESET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '1); // R3
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1)); // R1
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    run && !modulus && !load_now && cnt_q == '0 |=> cnt_q == '0); // R4
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    reload_evt |=> cnt_q == $past(reload_val)); // R5
  AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    run && load_now |=> cnt_q == $past(load_val)); // R6
endmodule

// File: rtl/mdc_regs.sv
module mdc_regs #(
  parameter int CNT_W = 16,
  parameter int SEL_W = 2,
  parameter int AW    = 2,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic             zero_hit,
  output logic [DW-1:0]    rdata,
  output logic             run,
  output logic             modulus,
  output logic [SEL_W-1:0] sel,
  output logic             load_now,
  output logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] load_q,
  output logic             irq
);
  import mdc_pkg::*;

  logic [SEL_W-1:0] sel_q;
  logic run_q, show_q, mod_q, ie_q, fast_q, flag_q;
  logic wr_ctrl, wr_stat, wr_cnt, acc_cnt;
  logic force_req, cnt_load_req, flag_clr;

  assign wr_ctrl = wr_en && (addr == AW'(ADR_CTRL));
  assign wr_stat = wr_en && (addr == AW'(ADR_STAT));
  assign wr_cnt  = wr_en && (addr == AW'(ADR_COUNT));
  assign acc_cnt = (wr_en || rd_en) && (addr == AW'(ADR_COUNT));

  assign force_req    = wr_ctrl && wdata[B_FORCE] && run_q;
  assign cnt_load_req = wr_cnt && mod_q && run_q;
  assign load_now     = force_req || cnt_load_req;
  assign load_val     = wr_cnt ? wdata[CNT_W-1:0] : load_q;

  assign flag_clr = (wr_stat && wdata[B_ZERO]) || (fast_q && acc_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      run_q  <= 1'b0;
      show_q <= 1'b0;
      mod_q  <= 1'b0;
      ie_q   <= 1'b0;
      fast_q <= 1'b0;
    end else if (wr_ctrl) begin
      sel_q  <= wdata[SEL_W-1:0];
      run_q  <= wdata[B_RUN];
      show_q <= wdata[B_SHOW];
      mod_q  <= wdata[B_MOD];
      ie_q   <= wdata[B_IE];
      fast_q <= wdata[B_FAST];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      load_q <= '0;
    else if (wr_cnt) load_q <= wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (zero_hit) flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(ADR_CTRL): begin
        rdata[SEL_W-1:0] = sel_q;
        rdata[B_RUN]     = run_q;
        rdata[B_SHOW]    = show_q;
        rdata[B_MOD]     = mod_q;
        rdata[B_IE]      = ie_q;
        rdata[B_FAST]    = fast_q;
      end
      AW'(ADR_STAT):  rdata[B_ZERO] = flag_q;
      AW'(ADR_COUNT): rdata = DW'(show_q ? load_q : cnt);
      default:        rdata = '0;
    endcase
  end

  assign run     = run_q;
  assign modulus = mod_q;
  assign sel     = sel_q;
  assign irq     = flag_q && ie_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hit |=> flag_q); // R8
  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && wr_stat && !wdata[B_ZERO] |=> flag_q); // R8
  AST_FAST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    fast_q && acc_cnt && !zero_hit |=> !flag_q); // R9
  AST_FORCE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && wdata[B_FORCE] && !run_q |-> !load_now); // R6
  AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rdata[B_ZERO] || addr != AW'(ADR_STAT)); // R10
endmodule

// File: rtl/modulus_downcounter.sv
module modulus_downcounter #(
  parameter int CNT_W = 16,
  parameter int SEL_W = 2,
  parameter int AW    = 2,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] load_q;
  logic [SEL_W-1:0] sel;
  logic             zero_hit;
  logic             run;
  logic             modulus;
  logic             load_now;

  mdc_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W), .AW(AW), .DW(DW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .cnt      (cnt),
    .zero_hit (zero_hit),
    .rdata    (rdata),
    .run      (run),
    .modulus  (modulus),
    .sel      (sel),
    .load_now (load_now),
    .load_val (load_val),
    .load_q   (load_q),
    .irq      (irq)
  );

  mdc_counter #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .modulus    (modulus),
    .load_now   (load_now),
    .load_val   (load_val),
    .reload_val (load_q),
    .sel_req    (sel),
    .cnt_q      (cnt),
    .zero_hit   (zero_hit)
  );
endmodule

// File: tb/modulus_downcounter_test.sv
`timescale 1ns/1ps
module modulus_downcounter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        irq;

  int nchk = 0;
  int nfail = 0;

  modulus_downcounter uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #4 clk = ~clk;

  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_CNT = 2'd2;

  function automatic logic [15:0] ctl(input int sel, input bit run, input bit frc,
                                      input bit show, input bit md, input bit ie,
                                      input bit fast);
    logic [15:0] v;
    v = 16'd0;
    v[1:0] = sel[1:0];
    v[2] = run; v[3] = frc; v[5] = show; v[6] = md; v[7] = ie; v[8] = fast;
    return v;
  endfunction

  function automatic int rate(input int sel);
    case (sel)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 16;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic touch(input logic [1:0] a);
    addr = a; rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] v);
    addr = a; rd_en = 1'b0;
    #1;
    v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    nchk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int n;
    int lens[3];
    lens[0] = 1; lens[1] = 2; lens[2] = 5;

    idle(3);
    rst_n = 1'b1;
    idle(1);

    // reset state and R3 preset while stopped
    peek(A_CTRL, v);  check("R3 ctrl after reset", v, 0);
    idle(20);
    peek(A_CNT, v);   check("R3 count stopped", v, 16'hFFFF);
    peek(A_STAT, v);  check("R3 no flag while stopped", v, 0);
    check("R10 irq after reset", irq, 0);

    // R1 / R4 sweep: cycles from force-load to irq
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 3; k++) begin
        wr(A_CTRL, ctl(s, 0, 0, 0, 0, 1, 0));
        wr(A_STAT, 16'h0080);
        wr(A_CNT, 16'(lens[k]));
        wr(A_CTRL, ctl(s, 1, 0, 0, 0, 1, 0));
        wr(A_CTRL, ctl(s, 1, 1, 0, 0, 1, 0));
        n = 0;
        while (!irq && n < 4000) begin
          @(negedge clk);
          n++;
        end
        check($sformatf("R1 sel=%0d len=%0d cycles", s, lens[k]), n, lens[k] * rate(s));
        idle(2 * rate(s) + 2);
        peek(A_CNT, v);
        check("R4 one-shot rests at zero", v, 0);
      end
    end

    // R2: rate change waits for a load
    wr(A_CTRL, ctl(0, 0, 0, 0, 0, 0, 0));
    wr(A_STAT, 16'h0080);
    wr(A_CNT, 16'd1000);
    wr(A_CTRL, ctl(0, 1, 0, 0, 0, 0, 0));
    wr(A_CTRL, ctl(0, 1, 1, 0, 0, 0, 0));
    wr(A_CTRL, ctl(3, 1, 0, 0, 0, 0, 0));
    peek(A_CNT, v); check("R2 old rate still used", v, 999);
    idle(4);
    peek(A_CNT, v); check("R2 old rate after 4", v, 995);
    wr(A_CTRL, ctl(3, 1, 1, 0, 0, 0, 0));
    peek(A_CNT, v); check("R6 force-load copies load", v, 1000);
    idle(15);
    peek(A_CNT, v); check("R2 new rate no step at 15", v, 1000);
    idle(1);
    peek(A_CNT, v); check("R2 new rate step at 16", v, 999);
    // R4: count write in one-shot leaves the count alone
    wr(A_CNT, 16'd7);
    peek(A_CNT, v); check("R4 one-shot write ignored by count", v, 999);
    wr(A_CTRL, ctl(3, 1, 0, 1, 0, 0, 0));
    peek(A_CNT, v); check("R7 read-select shows load", v, 7);
    wr(A_CTRL, ctl(3, 1, 1, 0, 0, 0, 0));
    peek(A_CTRL, v); check("R6 force bit reads zero", v, ctl(3, 1, 0, 0, 0, 0, 0));
    peek(A_CNT, v); check("R7 read-select live count", v, 7);

    // R5: modulus refill sequence 3,2,1,0,3,...
    wr(A_CTRL, ctl(0, 0, 0, 0, 1, 0, 0));
    wr(A_STAT, 16'h0080);
    wr(A_CTRL, ctl(0, 1, 0, 0, 1, 0, 0));
    wr(A_CNT, 16'd3);
    for (int k = 0; k < 9; k++) begin
      peek(A_CNT, v);
      check($sformatf("R5 modulus step %0d", k), v, 3 - (k % 4));
      @(negedge clk);
    end

    // R8 flag write rules and set/clear collision; R10 irq gating
    wr(A_CTRL, ctl(0, 0, 0, 0, 1, 1, 0));
    wr(A_STAT, 16'h0080);
    wr(A_CTRL, ctl(0, 1, 0, 0, 1, 1, 0));
    wr(A_CNT, 16'd3);            // load lands at edge E
    idle(4);                      // after E+4, flag set at E+3
    check("R8 flag set at zero", irq, 1);
    wr(A_STAT, 16'h0000);         // lands E+5
    check("R8 write zero keeps flag", irq, 1);
    wr(A_STAT, 16'h0080);         // lands E+6
    check("R8 write one clears flag", irq, 0);
    wr(A_STAT, 16'h0080);         // lands E+7, same edge as zero
    check("R8 set wins over clear", irq, 1);
    wr(A_CTRL, ctl(0, 1, 0, 0, 1, 0, 0));
    check("R10 irq masked", irq, 0);
    peek(A_STAT, v); check("R10 flag still visible", v, 16'h0080);

    // R9 fast clear on count access
    wr(A_CTRL, ctl(0, 0, 0, 0, 0, 0, 0));
    touch(A_CNT);
    peek(A_STAT, v); check("R9 no clear when fast off", v, 16'h0080);
    wr(A_CTRL, ctl(0, 0, 0, 0, 0, 0, 1));
    touch(A_CNT);
    peek(A_STAT, v); check("R9 access clears flag", v, 0);

    // R6 force while stopped does nothing; R3 preset
    wr(A_CTRL, ctl(0, 0, 1, 0, 0, 0, 0));
    idle(2);
    peek(A_CNT, v); check("R6 force ignored when stopped", v, 16'hFFFF);
    peek(A_STAT, v); check("R3 no flag while stopped", v, 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule